// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a device in reset after power-on until every start-up delay that applies to the selected oscillator mode has expired. A power-on pulse starts the sequence. A slow reference tick from the internal oscillator paces three timers: the power-up timer, the PLL lock timer and the controller-ready timer. A separate tick, one per oscillator-clock cycle, paces the oscillator start-up timer. Both ticks arrive as single-cycle enables that are synchronous to the block clock, so every count and the final release happen on edges of that clock.

The oscillator mode and the active-low power-up-timer enable are read on the power-on pulse. Each timer is armed only if it applies to that mode. The ready timer always runs, and it runs in parallel with the others from power-on. The PLL lock timer is the only delay that is chained: it starts counting when the start-up timer finishes. A new power-on pulse at any point clears every counter and starts the sequence again. One busy flag per timer shows which delays are still running.

Top module: `pwrup_hold_seq`

## Requirements
- R1: After the asynchronous reset and before the first power-on pulse, `hold_o` is 1 and all four busy flags are 0.
- R2: In the clock after a cycle with `por_i`=1, `rdy_busy_o` is 1, `hold_o` is 1, and the other flags show exactly the timers that apply to the mode code and enable bit seen in that cycle.
- R3: The power-up timer is armed only when `pwrt_en_n_i`=0. It counts PWRT_TICKS reference ticks, and `pwrt_busy_o` falls in the clock after the last of them.
- R4: The start-up timer is armed for mode codes 0 (XT), 1 (HS) and 2 (HS with PLL). It counts OST_CYCLES oscillator ticks.
- R5: The lock timer is armed only for mode code 2. It counts LOCK_TICKS reference ticks, and a tick counts only in cycles where `ost_busy_o` is already 0.
- R6: The ready timer is armed on every power-on pulse. It counts RDY_TICKS reference ticks, starting from the pulse and in parallel with the other timers.
- R7: For mode codes 3 (EC), 4 (internal) and any other unused code, the start-up and lock timers stay idle. Only the ready timer runs, plus the power-up timer when it is enabled.
- R8: `hold_o` falls one clock after the last armed busy flag clears. It is 1 whenever any busy flag is 1, and it rises again only after a power-on pulse.
- R9: A power-on pulse during a running sequence restarts every armed timer from zero. Ticks in the cycle of the pulse are not counted.
- R10: Changes to `osc_mode_i` or `pwrt_en_n_i` between power-on pulses have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on pulse; starts or restarts the sequence |
| ref_tick_i | input | 1 | Reference oscillator tick enable |
| osc_tick_i | input | 1 | Oscillator-clock cycle enable |
| pwrt_en_n_i | input | 1 | Power-up timer enable, active low |
| osc_mode_i | input | 3 | Mode: 0 XT, 1 HS, 2 HS+PLL, 3 EC, 4 internal |
| hold_o | output | 1 | Keep device in reset |
| pwrt_busy_o | output | 1 | Power-up timer running |
| ost_busy_o | output | 1 | Oscillator start-up timer running |
| lock_busy_o | output | 1 | PLL lock timer running |
| rdy_busy_o | output | 1 | Controller-ready timer running |

## Verification
A counter that is off by one shows up as a busy flag that falls one tick early or late, and the per-cycle comparison catches it on that exact clock. A wrong mode decode arms the wrong timer, which is visible in the clock right after the power-on pulse. A lock timer that ignores the chaining rule counts while the start-up timer is still busy, so `lock_busy_o` falls too early, within about LOCK_TICKS reference ticks. A restart that fails to clear a counter moves the release clock of the second sequence, so the comparison reports it at the release of that sequence.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
    typedef enum logic [2:0] {
        MODE_XT    = 3'd0,
        MODE_HS    = 3'd1,
        MODE_HSPLL = 3'd2,
        MODE_EC    = 3'd3,
        MODE_INT   = 3'd4
    } osc_mode_e;

    typedef struct packed {
        logic armed;
        logic hold;
    } seq_state_t;

    typedef struct packed {
        logic pwrt;
        logic ost;
        logic lock;
    } need_t;
endpackage

// File: rtl/pwrup_mode_decode.sv
module pwrup_mode_decode
    import pwrup_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       pwrt_en_n_i,
    output need_t      need_o
);
    always_comb begin
        need_o      = '0;
        need_o.pwrt = ~pwrt_en_n_i;
        unique case (mode_i)
            MODE_XT, MODE_HS: need_o.ost = 1'b1;
            MODE_HSPLL: begin
                need_o.ost  = 1'b1;
                need_o.lock = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic arm_i,
    input  logic cnt_en_i,
    output logic busy_o
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = arm_i;
            st_d.cnt  = '0;
        end else if (st_q.busy && cnt_en_i) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/pwrup_hold_seq.sv
module pwrup_hold_seq
    import pwrup_pkg::*;
#(
    parameter int unsigned PWRT_TICKS = 72,
    parameter int unsigned OST_CYCLES = 1024,
    parameter int unsigned LOCK_TICKS = 64,
    parameter int unsigned RDY_TICKS  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       ref_tick_i,
    input  logic       osc_tick_i,
    input  logic       pwrt_en_n_i,
    input  logic [2:0] osc_mode_i,
    output logic       hold_o,
    output logic       pwrt_busy_o,
    output logic       ost_busy_o,
    output logic       lock_busy_o,
    output logic       rdy_busy_o
);
    need_t      need;
    seq_state_t st_d, st_q;
    logic       any_busy;

    pwrup_mode_decode u_dec (
        .mode_i      (osc_mode_i),
        .pwrt_en_n_i (pwrt_en_n_i),
        .need_o      (need)
    );

    pwrup_tick_timer #(.LEN(PWRT_TICKS)) u_pwrt (
        .clk(clk), .rst_n(rst_n), .start_i(por_i), .arm_i(need.pwrt),
        .cnt_en_i(ref_tick_i), .busy_o(pwrt_busy_o)
    );

    pwrup_tick_timer #(.LEN(OST_CYCLES)) u_ost (
        .clk(clk), .rst_n(rst_n), .start_i(por_i), .arm_i(need.ost),
        .cnt_en_i(osc_tick_i), .busy_o(ost_busy_o)
    );

    pwrup_tick_timer #(.LEN(LOCK_TICKS)) u_lock (
        .clk(clk), .rst_n(rst_n), .start_i(por_i), .arm_i(need.lock),
        .cnt_en_i(ref_tick_i & ~ost_busy_o), .busy_o(lock_busy_o)
    );

    pwrup_tick_timer #(.LEN(RDY_TICKS)) u_rdy (
        .clk(clk), .rst_n(rst_n), .start_i(por_i), .arm_i(1'b1),
        .cnt_en_i(ref_tick_i), .busy_o(rdy_busy_o)
    );

    assign any_busy = pwrt_busy_o | ost_busy_o | lock_busy_o | rdy_busy_o;

    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | por_i;
        st_d.hold  = por_i | ~st_q.armed | any_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, hold: 1'b1};
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/pwrup_hold_seq_chk.sv
module pwrup_hold_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic por_i,
    input logic hold_o,
    input logic pwrt_busy_o,
    input logic ost_busy_o,
    input logic lock_busy_o,
    input logic rdy_busy_o
);
    logic busy_any;
    assign busy_any = pwrt_busy_o | ost_busy_o | lock_busy_o | rdy_busy_o;

    AST_POR_ARMS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (rdy_busy_o && hold_o));                              // R6
    AST_BUSY_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_any |-> hold_o);                                           // R8
    AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> $past(!busy_any && !por_i));                  // R8
    AST_HOLD_ONLY_ON_POR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(por_i));                                // R8
    AST_LOCK_ENDS_AFTER_OST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_busy_o) && !$past(por_i)) |-> !ost_busy_o);         // R5
    AST_LOCK_WITH_OST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_busy_o) |-> ost_busy_o);                             // R5
    AST_RISE_ONLY_ON_POR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwrt_busy_o) || $rose(ost_busy_o) || $rose(rdy_busy_o)) |-> $past(por_i)); // R9
endmodule

bind pwrup_hold_seq pwrup_hold_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .hold_o(hold_o),
    .pwrt_busy_o(pwrt_busy_o), .ost_busy_o(ost_busy_o),
    .lock_busy_o(lock_busy_o), .rdy_busy_o(rdy_busy_o)
);

// File: tb/sim_pwrup_hold_seq.sv
module sim_pwrup_hold_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PW  = 72;
    localparam int OST = 1024;
    localparam int LK  = 64;
    localparam int RDY = 8;
    localparam int REF_DIV = 4;
    localparam int OSC_DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0, ref_tick = 1'b0, osc_tick = 1'b0, pwrt_en_n = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       hold, b_pw, b_ost, b_lk, b_rdy;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    // behavioural reference model: remaining ticks per timer
    int  m_pw = 0, m_ost = 0, m_lk = 0, m_rdy = 0;
    bit  m_armed = 0, m_hold = 1;
    int  ost_seen = 0;

    pwrup_hold_seq u0 (
        .clk(clk), .rst_n(rst_n), .por_i(por), .ref_tick_i(ref_tick),
        .osc_tick_i(osc_tick), .pwrt_en_n_i(pwrt_en_n), .osc_mode_i(mode),
        .hold_o(hold), .pwrt_busy_o(b_pw), .ost_busy_o(b_ost),
        .lock_busy_o(b_lk), .rdy_busy_o(b_rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pw = 0; m_ost = 0; m_lk = 0; m_rdy = 0; m_armed = 0; m_hold = 1;
        end else if (por) begin
            m_pw  = (pwrt_en_n == 1'b0) ? PW : 0;
            m_ost = (mode <= 3'd2) ? OST : 0;
            m_lk  = (mode == 3'd2) ? LK : 0;
            m_rdy = RDY;
            m_armed = 1; m_hold = 1;
        end else begin
            automatic int ost_old = m_ost;
            m_hold = !m_armed || (m_pw + m_ost + m_lk + m_rdy) > 0;
            if (ref_tick && m_pw > 0) m_pw--;
            if (osc_tick && m_ost > 0) m_ost--;
            if (ref_tick && m_lk > 0 && ost_old == 0) m_lk--;
            if (ref_tick && m_rdy > 0) m_rdy--;
        end
    end

    // tick generators and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        ref_tick <= (cyc % REF_DIV) == 0;
        osc_tick <= (cyc % OSC_DIV) == 1;
        if (b_ost) ost_seen++;
        if (cmp_on) begin
            check("R8 hold", hold, m_hold);
            check("R3 pwrt", b_pw, m_pw > 0);
            check("R4 ost", b_ost, m_ost > 0);
            check("R5 lock", b_lk, m_lk > 0);
            check("R6 rdy", b_rdy, m_rdy > 0);
        end
        if (cyc > 190000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic pulse_por(input logic [2:0] md, input logic en_n);
        @(negedge clk);
        mode = md; pwrt_en_n = en_n; por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        // R2: flags right after the pulse
        check("R2 rdy", b_rdy, 1'b1);
        check("R2 hold", hold, 1'b1);
        check("R2 pwrt", b_pw, !en_n);
        check("R2 ost", b_ost, md <= 3'd2);
        check("R2 lock", b_lk, md == 3'd2);
    endtask

    task automatic run_mode(input logic [2:0] md, input logic en_n);
        ost_seen = 0;
        pulse_por(md, en_n);
        for (int i = 0; i < 4000 && m_hold; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R8 released", hold, 1'b0);
        if (md > 3'd2) check("R7 no ost", ost_seen != 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hold", hold, 1'b1);
        check("R1 flags", b_pw | b_ost | b_lk | b_rdy, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 hold idle", hold, 1'b1);
        check("R1 flags idle", b_pw | b_ost | b_lk | b_rdy, 1'b0);
        cmp_on = 1'b1;
        for (int m = 0; m < 5; m++) begin
            run_mode(3'(m), 1'b0);
            run_mode(3'(m), 1'b1);
        end
        run_mode(3'd7, 1'b0);               // R7 unused code
        // R9: restart mid-sequence
        pulse_por(3'd2, 1'b0);
        repeat (700) @(negedge clk);
        run_mode(3'd2, 1'b0);               // R9 restart, compared per cycle
        // R10: config changes mid-sequence are ignored
        pulse_por(3'd3, 1'b1);
        mode = 3'd2; pwrt_en_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 no ost", b_ost, 1'b0);
        check("R10 no pwrt", b_pw, 1'b0);
        repeat (60) @(negedge clk);
        check("R10 released", hold, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule